// File: doc/BRIEF.md
# Serial EEPROM Word Address Counter

This block keeps the internal byte address of a 1024-byte serial EEPROM. The protocol engine loads it after the device-address byte and the word-address byte have been received. The two block-select bits from the device address form the upper part, and the word byte forms the lower part. After every byte the array reads or writes, the engine pulses one of two increment strobes.

The two strobes wrap differently. A read increment steps through the whole array and wraps from the top address to zero. A write increment stays inside the current 16-byte page, so only the four offset bits change. The counter holds its value between transactions. A current-address read therefore uses the stored value as it stands, and a random read uses the value loaded by its dummy write.

The three strobes are decoded into one operation per cycle, of type `op_t`, with these states:
- `OP_HOLD`: no strobe is active.
- `OP_LOAD`: a load is requested. It wins over both increments.
- `OP_RDINC`: a read increment is requested and no load. It wins over a write increment.
- `OP_WRINC`: only a write increment is requested.

Each state makes the registered address move to its next value at the following clock edge:
- `OP_HOLD` keeps the address.
- `OP_LOAD` replaces the address with the loaded value.
- `OP_RDINC` adds one to the offset. When the offset was 15, the page row also advances.
- `OP_WRINC` adds one to the offset only.

Top module: `eeaddr_ctr`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it is released, `addr_o` is 0.
- R2: A cycle with `ld_i` high makes `addr_o` equal `{ld_blk_i, ld_word_i}` after the next rising edge. `ld_blk_i` forms bits [9:8].
- R3: A read increment (`rd_inc_i` high, `ld_i` low) makes the next `addr_o` equal the present value plus one, modulo 1024. A carry out of bits [3:0] advances bits [9:4].
- R4: A read increment at address 1023 gives address 0.
- R5: A write increment (`wr_inc_i` high, `rd_inc_i` and `ld_i` low) adds one to bits [3:0] modulo 16 and leaves bits [9:4] unchanged. For example, 0x1FF becomes 0x1F0.
- R6: When `ld_i` is high together with either increment strobe, only the load takes effect.
- R7: When `rd_inc_i` and `wr_inc_i` are both high and `ld_i` is low, the read-increment rule applies.
- R8: With no strobe active, `addr_o` keeps its value for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_i | input | 1 | Load strobe |
| ld_blk_i | input | 2 | Block-select bits from the device address (address bits [9:8]) |
| ld_word_i | input | 8 | Word-address byte (address bits [7:0]) |
| rd_inc_i | input | 1 | Read increment strobe, whole-array wrap |
| wr_inc_i | input | 1 | Write increment strobe, in-page wrap |
| addr_o | output | 10 | Current byte address |

## Verification
On every cycle, the assertions check the following:
- the load result;
- the read step, including the carry into the page row;
- the write step, which keeps the row fixed;
- the read-over-write priority;
- the holding of the value when no strobe is active.

Some behaviour can only be shown by the bench's scenarios, which compare `addr_o` each cycle against a behavioural model. These are the reset value and the exact wrap points: 1023 to 0 on reads, and offset 15 to offset 0 of the same page on writes. They also cover long runs that mix loads and increments of both kinds, which resemble random reads, sequential reads and page writes.

// File: rtl/eeaddr_pkg.sv
package eeaddr_pkg;

    // Decoded operation for one cycle, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_RDINC = 2'd2,
        OP_WRINC = 2'd3
    } op_t;

endpackage

// File: rtl/eeaddr_arb.sv
module eeaddr_arb
    import eeaddr_pkg::*;
(
    input  logic ld_i,
    input  logic rd_inc_i,
    input  logic wr_inc_i,
    output op_t  op_o
);

    // Load beats read increment, read increment beats write increment.
    always_comb begin
        if (ld_i)
            op_o = OP_LOAD;
        else if (rd_inc_i)
            op_o = OP_RDINC;
        else if (wr_inc_i)
            op_o = OP_WRINC;
        else
            op_o = OP_HOLD;
    end

endmodule

// File: rtl/eeaddr_offset.sv
module eeaddr_offset
    import eeaddr_pkg::*;
#(
    parameter int OFFS_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  op_t               op_i,
    input  logic [OFFS_W-1:0] ld_offs_i,
    output logic [OFFS_W-1:0] offs_o,
    output logic              top_o
);

    localparam logic [OFFS_W-1:0] OFFS_MAX = {OFFS_W{1'b1}};

    logic [OFFS_W-1:0] offs_q;
    logic [OFFS_W-1:0] offs_d;

    always_comb begin
        offs_d = offs_q;
        unique case (op_i)
            OP_HOLD:  offs_d = offs_q;
            OP_LOAD:  offs_d = ld_offs_i;
            OP_RDINC: offs_d = offs_q + OFFS_W'(1);
            OP_WRINC: offs_d = offs_q + OFFS_W'(1);
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            offs_q <= '0;
        else
            offs_q <= offs_d;
    end

    assign offs_o = offs_q;
    assign top_o  = (offs_q == OFFS_MAX);

    // R5: any increment at the page top returns the offset to zero.
    assert_offs_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((op_i == OP_WRINC || op_i == OP_RDINC) && top_o) |=> (offs_o == '0));

endmodule

// File: rtl/eeaddr_row.sv
module eeaddr_row
    import eeaddr_pkg::*;
#(
    parameter int ROW_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  op_t              op_i,
    input  logic             carry_i,
    input  logic [ROW_W-1:0] ld_row_i,
    output logic [ROW_W-1:0] row_o
);

    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] row_d;

    always_comb begin
        row_d = row_q;
        unique case (op_i)
            OP_HOLD:  row_d = row_q;
            OP_LOAD:  row_d = ld_row_i;
            OP_RDINC: row_d = carry_i ? row_q + ROW_W'(1) : row_q;
            OP_WRINC: row_d = row_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            row_q <= '0;
        else
            row_q <= row_d;
    end

    assign row_o = row_q;

    // R5: a write increment never moves the page row.
    assert_row_fixed_on_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_WRINC) |=> $stable(row_o));

endmodule

// File: rtl/eeaddr_ctr.sv
module eeaddr_ctr
    import eeaddr_pkg::*;
#(
    parameter int BLK_W  = 2,
    parameter int WORD_W = 8,
    parameter int OFFS_W = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    ld_i,
    input  logic [BLK_W-1:0]        ld_blk_i,
    input  logic [WORD_W-1:0]       ld_word_i,
    input  logic                    rd_inc_i,
    input  logic                    wr_inc_i,
    output logic [BLK_W+WORD_W-1:0] addr_o
);

    localparam int ADDR_W = BLK_W + WORD_W;
    localparam int ROW_W  = ADDR_W - OFFS_W;

    op_t               op;
    logic [ADDR_W-1:0] ld_full;
    logic [OFFS_W-1:0] offs;
    logic [ROW_W-1:0]  row;
    logic              offs_top;

    assign ld_full = {ld_blk_i, ld_word_i};

    eeaddr_arb u_arb (
        .ld_i     (ld_i),
        .rd_inc_i (rd_inc_i),
        .wr_inc_i (wr_inc_i),
        .op_o     (op)
    );

    eeaddr_offset #(.OFFS_W(OFFS_W)) u_offs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .op_i      (op),
        .ld_offs_i (ld_full[OFFS_W-1:0]),
        .offs_o    (offs),
        .top_o     (offs_top)
    );

    eeaddr_row #(.ROW_W(ROW_W)) u_row (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .op_i     (op),
        .carry_i  (offs_top),
        .ld_row_i (ld_full[ADDR_W-1:OFFS_W]),
        .row_o    (row)
    );

    assign addr_o = {row, offs};

    assert_load_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_i |=> (addr_o == $past({ld_blk_i, ld_word_i})));

    assert_read_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_inc_i && !ld_i) |=> (addr_o == $past(addr_o) + ADDR_W'(1)));

    assert_load_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_i && (rd_inc_i || wr_inc_i)) |=> (addr_o == $past(ld_full)));

    assert_write_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_inc_i && !rd_inc_i && !ld_i) |=>
        ((addr_o[ADDR_W-1:OFFS_W] == $past(addr_o[ADDR_W-1:OFFS_W])) &&
         (addr_o[OFFS_W-1:0] == $past(addr_o[OFFS_W-1:0]) + OFFS_W'(1))));

    assert_read_beats_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_inc_i && wr_inc_i && !ld_i) |=> (addr_o == $past(addr_o) + ADDR_W'(1)));

    assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ld_i && !rd_inc_i && !wr_inc_i) |=> $stable(addr_o));

endmodule

// File: tb/eeaddr_ctr_tb_top.sv
`timescale 1ns/1ps
module eeaddr_ctr_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld = 1'b0;
    logic [1:0] blk = '0;
    logic [7:0] word = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [9:0] addr;

    int checks = 0;
    int failures = 0;
    int model = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    eeaddr_ctr dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .ld_i      (ld),
        .ld_blk_i  (blk),
        .ld_word_i (word),
        .rd_inc_i  (rd),
        .wr_inc_i  (wr),
        .addr_o    (addr)
    );

    function automatic int next_addr(int a, bit l, bit r, bit w, int b, int wd);
        if (l) return b * 256 + wd;
        if (r) return (a + 1) % 1024;
        if (w) return (a / 16) * 16 + ((a % 16) + 1) % 16;
        return a;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) model <= 0;
        else model <= next_addr(model, ld, rd, wr, int'(blk), int'(word));
    end

    task automatic check(string req, int expv);
        checks++;
        if (int'(addr) !== expv) begin
            failures++;
            $display("FAIL %s addr=0x%03h expected=0x%03h", req, addr, expv[9:0]);
        end
    endtask

    // Drive one cycle of strobes, then compare against the model and an explicit value.
    task automatic step(bit l, bit r, bit w, int a, string req, int expv);
        @(negedge clk);
        ld = l; rd = r; wr = w;
        blk = 2'(a >> 8); word = 8'(a);
        @(posedge clk);
        #1;
        check(req, model);
        if (expv >= 0) check(req, expv);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1", 0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 check("R1", 0);

        step(1, 0, 0, 'h2A5, "R2", 'h2A5);
        step(0, 0, 0, 0, "R8", 'h2A5);
        step(0, 0, 0, 'h111, "R8", 'h2A5);
        step(0, 1, 0, 0, "R3", 'h2A6);
        step(1, 0, 0, 'h0AF, "R2", 'h0AF);
        step(0, 1, 0, 0, "R3", 'h0B0);
        step(1, 0, 0, 'h3FE, "R2", 'h3FE);
        step(0, 1, 0, 0, "R4", 'h3FF);
        step(0, 1, 0, 0, "R4", 'h000);
        step(1, 0, 0, 'h1FD, "R2", 'h1FD);
        step(0, 0, 1, 0, "R5", 'h1FE);
        step(0, 0, 1, 0, "R5", 'h1FF);
        step(0, 0, 1, 0, "R5", 'h1F0);
        step(0, 0, 1, 0, "R5", 'h1F1);
        step(1, 0, 0, 'h3FF, "R2", 'h3FF);
        step(0, 0, 1, 0, "R5", 'h3F0);
        step(1, 1, 0, 'h123, "R6", 'h123);
        step(1, 0, 1, 'h05F, "R6", 'h05F);
        step(1, 1, 1, 'h200, "R6", 'h200);
        step(1, 0, 0, 'h0CF, "R2", 'h0CF);
        step(0, 1, 1, 0, "R7", 'h0D0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, "R8", 'h0D0);

        for (int i = 0; i < 400; i++) begin
            int sel = $urandom_range(0, 9);
            step(sel == 0, sel inside {[1:4]}, sel inside {[3:7]},
                 $urandom_range(0, 1023), "R3/R5 mix", -1);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule